// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a requester and a small dynamic storage array of 16 byte-wide cells, arranged as 4 rows of 4 columns. The requester issues single-cell reads and writes over a valid/ready handshake. A request carries a 4-bit cell address, a write flag and a write byte. The sequencer reaches the array over one shared 2-bit address bus. It first presents the row with the row strobe raised, which copies the whole row into an internal row buffer. It then presents the column with the column strobe raised, which selects one byte from that buffer. The row closes in a precharge phase, and the buffer is written back to the array there.

The stored contents are dynamic, so the block refreshes them on its own. A timer raises a refresh request every `REF_INTERVAL` cycles. The interval is a scaled stand-in for a real-time period of roughly 10 to 100 ms. Each refresh opens the next row in sequence with the row strobe only, and writes that row back unchanged. A pending refresh wins over any waiting request. The array itself is a behavioural register model inside the block, and it resets to all zero. The strobe and address-bus pins are brought out so that the access sequence can be observed.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset is released, `req_ready_o` is 1, and `bus_ras_o`, `bus_cas_o` and `rsp_valid_o` are all 0.
- R2: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both 1. The cell address splits into row = `req_addr_i[3:2]` and column = `req_addr_i[1:0]`. The row goes on `bus_addr_o` while the row strobe alone is high, and the column goes on `bus_addr_o` while the column strobe is high.
- R3: After acceptance, `bus_ras_o` is high alone for `T_RAS` cycles. Then `bus_ras_o` and `bus_cas_o` are both high for `T_CAS` cycles. `bus_cas_o` is never high unless `bus_ras_o` is high.
- R4: A read (`req_we_i` = 0) returns the byte last written to that cell, or 0 if the cell has never been written. The byte appears on `rsp_rdata_o` with `rsp_valid_o` high for exactly one cycle, starting after the `T_RAS+T_CAS`-th rising edge that follows the accepting edge.
- R5: A write (`req_we_i` = 1) stores `req_wdata_i` into the addressed cell, leaves the other cells unchanged, and produces no `rsp_valid_o` pulse.
- R6: Refresh requests arise every `REF_INTERVAL` cycles. Each refresh raises `bus_ras_o` without `bus_cas_o`, with the refresh row on `bus_addr_o`. Refresh rows go 0, 1, 2, 3 and then wrap to 0. Refresh leaves all stored data unchanged.
- R7: A pending refresh starts before any new request is accepted, and `req_ready_o` is 0 while a refresh is pending or running. Under back-to-back traffic, at least floor(cycles/`REF_INTERVAL`) − 1 refreshes still occur.
- R8: `req_ready_o` is 0 in every cycle in which either strobe is high, and in the precharge cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Cell address: row in [3:2], column in [1:0] |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle read response flag |
| rsp_rdata_o | output | 8 | Read byte |
| bus_addr_o | output | 2 | Shared row/column address bus |
| bus_ras_o | output | 1 | Row strobe |
| bus_cas_o | output | 1 | Column strobe |

## Verification
Directed writes and reads cover every cell, including the first and last addresses. They tell a correct row/column split apart from swapped or misrouted halves. They also show whether the write-back really reaches the array, since every row is re-read after it has been closed. A seeded random mix of reads and writes to random cells compares each response against a bench memory model. It separates the write-back from the buffer-only path, and it catches stale row-buffer data between different rows. Back-to-back traffic kept up for many refresh intervals shows whether refresh still wins over requests. A long idle stretch followed by a full readback shows whether refresh changes any data, and the strobe monitor checks the refresh row order throughout.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAS,
    ST_CAS,
    ST_PRE,
    ST_REF
  } seq_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int REF_INTERVAL = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pending_o
);
  localparam int TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

  logic [TW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pending_o <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)       pending_o <= 1'b1;
      else if (ack_i) pending_o <= 1'b0;
    end
  end

  AST_PENDING_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && !ack_i |=> pending_o); // R6
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int HALF_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] row_i,
  input  logic [HALF_W-1:0] col_i,
  input  logic              load_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wb_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ROWS  = 1 << HALF_W;
  localparam int COLS  = 1 << HALF_W;
  localparam int LINE_W = COLS * DATA_W;

  logic [LINE_W-1:0] mem_q [ROWS];
  logic [LINE_W-1:0] rowbuf_q;
  logic [HALF_W-1:0] open_row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
      rowbuf_q   <= '0;
      open_row_q <= '0;
    end else begin
      if (load_i) begin
        rowbuf_q   <= mem_q[row_i];
        open_row_q <= row_i;
      end else if (wr_i) begin
        for (int c = 0; c < COLS; c++)
          if (col_i == HALF_W'(c)) rowbuf_q[c*DATA_W +: DATA_W] <= wdata_i;
      end
      if (wb_i) mem_q[open_row_q] <= rowbuf_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < COLS; c++)
      if (col_i == HALF_W'(c)) rdata_o = rowbuf_q[c*DATA_W +: DATA_W];
  end

  // buffer must never be reloaded while it is being written back
  AST_NO_LOAD_DURING_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_i |-> !load_i); // R6
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_mux_pkg::*;
#(
  parameter int HALF_W = 2,
  parameter int DATA_W = 8,
  parameter int T_RAS  = 2,
  parameter int T_CAS  = 2,
  parameter int T_PRE  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  input  logic [2*HALF_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                req_ready_o,
  input  logic                ref_pending_i,
  output logic                ref_ack_o,
  output logic                ras_o,
  output logic                cas_o,
  output logic [HALF_W-1:0]   bus_addr_o,
  output logic [HALF_W-1:0]   arr_row_o,
  output logic [HALF_W-1:0]   arr_col_o,
  output logic                arr_load_o,
  output logic                arr_wr_o,
  output logic [DATA_W-1:0]   arr_wdata_o,
  output logic                arr_wb_o,
  input  logic [DATA_W-1:0]   arr_rdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o
);
  localparam int T_MAX = (T_RAS > T_CAS) ? ((T_RAS > T_PRE) ? T_RAS : T_PRE)
                                         : ((T_CAS > T_PRE) ? T_CAS : T_PRE);
  localparam int CNT_W = $clog2(T_MAX + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HALF_W-1:0] row_q, col_q, ref_row_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              last;

  always_comb begin
    unique case (state_q)
      ST_RAS, ST_REF: last = (cnt_q == CNT_W'(T_RAS - 1));
      ST_CAS:         last = (cnt_q == CNT_W'(T_CAS - 1));
      ST_PRE:         last = (cnt_q == CNT_W'(T_PRE - 1));
      default:        last = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      row_q       <= '0;
      col_q       <= '0;
      ref_row_q   <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      cnt_q       <= last ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (ref_pending_i) begin
            state_q <= ST_REF;
          end else if (req_valid_i) begin
            state_q <= ST_RAS;
            row_q   <= req_addr_i[2*HALF_W-1:HALF_W];
            col_q   <= req_addr_i[HALF_W-1:0];
            we_q    <= req_we_i;
            wdata_q <= req_wdata_i;
          end
        end
        ST_RAS: if (last) state_q <= ST_CAS;
        ST_CAS: if (last) begin
          state_q <= ST_PRE;
          if (!we_q) begin
            rsp_valid_o <= 1'b1;
            rsp_rdata_o <= arr_rdata_i;
          end
        end
        ST_PRE: if (last) state_q <= ST_IDLE;
        ST_REF: if (last) begin
          state_q   <= ST_PRE;
          ref_row_q <= ref_row_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE) && !ref_pending_i;
  assign ref_ack_o   = (state_q == ST_IDLE) && ref_pending_i;
  assign ras_o       = (state_q == ST_RAS) || (state_q == ST_CAS) || (state_q == ST_REF);
  assign cas_o       = (state_q == ST_CAS);
  assign bus_addr_o  = (state_q == ST_CAS) ? col_q :
                       (state_q == ST_REF) ? ref_row_q : row_q;
  assign arr_row_o   = (state_q == ST_REF) ? ref_row_q : row_q;
  assign arr_col_o   = col_q;
  assign arr_load_o  = (state_q == ST_RAS) || (state_q == ST_REF);
  assign arr_wr_o    = (state_q == ST_CAS) && last && we_q;
  assign arr_wdata_o = wdata_q;
  assign arr_wb_o    = (state_q == ST_PRE);

  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_o |-> ras_o); // R3
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !ras_o && !cas_o); // R8
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R4
  AST_RSP_AFTER_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(cas_o)); // R4
  AST_REF_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_row_q != $past(ref_row_q)) |-> (ref_row_q == HALF_W'($past(ref_row_q) + 1'b1))); // R6
  AST_REF_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pending_i |-> !req_ready_o); // R7
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int HALF_W       = 2,
  parameter int DATA_W       = 8,
  parameter int T_RAS        = 2,
  parameter int T_CAS        = 2,
  parameter int T_PRE        = 2,
  parameter int REF_INTERVAL = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [2*HALF_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [HALF_W-1:0]   bus_addr_o,
  output logic                bus_ras_o,
  output logic                bus_cas_o
);
  logic              ref_pending, ref_ack;
  logic [HALF_W-1:0] arr_row, arr_col;
  logic              arr_load, arr_wr, arr_wb;
  logic [DATA_W-1:0] arr_wdata, arr_rdata;

  dram_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ack_i    (ref_ack),
    .pending_o(ref_pending)
  );

  dram_seq_fsm #(
    .HALF_W(HALF_W), .DATA_W(DATA_W),
    .T_RAS(T_RAS), .T_CAS(T_CAS), .T_PRE(T_PRE)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_we_i     (req_we_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .req_ready_o  (req_ready_o),
    .ref_pending_i(ref_pending),
    .ref_ack_o    (ref_ack),
    .ras_o        (bus_ras_o),
    .cas_o        (bus_cas_o),
    .bus_addr_o   (bus_addr_o),
    .arr_row_o    (arr_row),
    .arr_col_o    (arr_col),
    .arr_load_o   (arr_load),
    .arr_wr_o     (arr_wr),
    .arr_wdata_o  (arr_wdata),
    .arr_wb_o     (arr_wb),
    .arr_rdata_i  (arr_rdata),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_rdata_o  (rsp_rdata_o)
  );

  dram_cell_array #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .row_i  (arr_row),
    .col_i  (arr_col),
    .load_i (arr_load),
    .wr_i   (arr_wr),
    .wdata_i(arr_wdata),
    .wb_i   (arr_wb),
    .rdata_o(arr_rdata)
  );
endmodule

// File: tb/dram_mux_ctrl_bench.sv
`timescale 1ns/1ps
module dram_mux_ctrl_bench;
  localparam int TR = 2, TC = 2, TP = 2, RI = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_we = 1'b0;
  logic       req_ready;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic [1:0] bus_addr;
  logic       ras, cas;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  logic [7:0] model [16];
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_mux_ctrl #(.T_RAS(TR), .T_CAS(TC), .T_PRE(TP), .REF_INTERVAL(RI)) u_dram_mux_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_addr_o(bus_addr), .bus_ras_o(ras), .bus_cas_o(cas)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    return model[a];
  endfunction

  // refresh monitor: a row strobe pulse with no column strobe is a refresh
  logic       prev_ras = 1'b0, saw_cas = 1'b0;
  logic [1:0] pulse_addr = '0, exp_ref_row = '0;
  int         ref_count = 0;
  always @(negedge clk) if (rst_n) begin
    if (ras && !prev_ras) begin pulse_addr = bus_addr; saw_cas = 1'b0; end
    if (cas) saw_cas = 1'b1;
    if (ras || cas) check(!req_ready, "R8 ready while strobe", req_ready, 0);
    if (cas) check(ras, "R3 cas without ras", ras, 1);
    if (!ras && prev_ras && !saw_cas) begin
      check(pulse_addr == exp_ref_row, "R6 refresh row order", pulse_addr, exp_ref_row);
      exp_ref_row = exp_ref_row + 1'b1;
      ref_count++;
    end
    prev_ras = ras;
  end

  task automatic access(input bit we, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= TR + TC; n++) begin
      if (n > 1) @(negedge clk);
      check(!req_ready, "R8 ready during access", req_ready, 0);
      check(rsp_valid == 1'b0, "R4 early response", rsp_valid, 0);
      if (n <= TR) begin
        check(ras && !cas, "R3 row phase strobes", {ras, cas}, 2);
        check(bus_addr == a[3:2], "R2 row on bus", bus_addr, a[3:2]);
      end else begin
        check(ras && cas, "R3 column phase strobes", {ras, cas}, 3);
        check(bus_addr == a[1:0], "R2 column on bus", bus_addr, a[1:0]);
      end
    end
    @(negedge clk);
    check(!ras && !cas, "R3 strobes drop", {ras, cas}, 0);
    check(!req_ready, "R8 ready in precharge", req_ready, 0);
    if (we) begin
      check(rsp_valid == 1'b0, "R5 no response on write", rsp_valid, 0);
      model[a] = d;
    end else begin
      check(rsp_valid == 1'b1, "R4 response valid", rsp_valid, 1);
      check(rsp_rdata == exp_read(a), "R4 read data", rsp_rdata, exp_read(a));
    end
    @(negedge clk);
    check(rsp_valid == 1'b0, "R4 one-cycle response", rsp_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(!ras && !cas, "R1 strobes low after reset", {ras, cas}, 0);
    check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);

    // R4 reset contents read as zero; corner cells
    access(1'b0, 4'd0, 8'h00);
    access(1'b0, 4'd15, 8'h00);
    // R5 fill every cell, then read back all
    for (int i = 0; i < 16; i++) access(1'b1, 4'(i), 8'(8'h5A ^ (i * 17)));
    for (int i = 15; i >= 0; i--) access(1'b0, 4'(i), 8'h00);
    // R5 same-row neighbours untouched by a write
    access(1'b1, 4'd5, 8'hFF);
    access(1'b0, 4'd4, 8'h00);
    access(1'b0, 4'd6, 8'h00);
    access(1'b0, 4'd5, 8'h00);

    // random mix
    for (int k = 0; k < 300; k++)
      access(1'($urandom_range(1)), 4'($urandom_range(15)), 8'($urandom));

    // R7 saturated traffic still refreshes
    begin
      int r0, c0;
      r0 = ref_count; c0 = cyc;
      for (int k = 0; k < 200; k++)
        access(1'($urandom_range(1)), 4'($urandom_range(15)), 8'($urandom));
      check(ref_count - r0 >= (cyc - c0) / RI - 1, "R7 refresh under load",
            ref_count - r0, (cyc - c0) / RI - 1);
    end

    // R6 idle stretch, then contents intact
    begin
      int r0;
      r0 = ref_count;
      repeat (RI * 6) @(negedge clk);
      check(ref_count - r0 >= 5, "R6 refresh while idle", ref_count - r0, 5);
      for (int i = 0; i < 16; i++) access(1'b0, 4'(i), 8'h00);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule